// File: doc/BRIEF.md
# Conversion Trigger Source Selector

This block decides when a data converter starts a conversion. It watches eight possible trigger sources and turns the one that is selected into a start pulse that lasts one clock cycle. The eight sources are a self-clearing software trigger bit, one asynchronous external pin, four timer event lines and two PWM event lines. The block resamples the external pin into the clock domain before it uses it. The pin can trigger on a low level, a high level, a falling edge or a rising edge.

Configuration arrives as plain fields: a trigger enable, a 3-bit source code and a 2-bit pin mode. The software trigger is written through a bus write strobe with a data bit. The converter reports whether it is idle, and the pin level modes use that report. The timer and PWM lines are assumed to carry single-cycle pulses that are already in the clock domain. The block forwards them one cycle later, in registered form.

Top module: `trig_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `start_o` is low.
- R2: Source code 2+n (n = 0..3) selects timer line `tmr_evt[n]`, and code 6+m (m = 0..1) selects `pwm_evt[m]`. A pulse on the selected line during cycle k gives `start_o` high in cycle k+1. A pulse on any line that is not selected gives no start.
- R3: Code 0 selects the software trigger. A bus write with `sw_wr`=1 and `sw_wdata`=1 in cycle k gives exactly one start pulse, in cycle k+2. A write of 0 gives none.
- R4: The software trigger bit clears itself after one cycle. If a 1 is written while another source is selected, no pulse appears later when code 0 is selected.
- R5: Code 1 selects the external pin. With pin mode 3 (rising edge) or mode 2 (falling edge), each matching edge of the pin gives exactly one start pulse. The pulse comes three clock edges after the pin changes, because of the two-flop synchroniser and the output register. A change in the opposite direction gives no pulse.
- R6: With pin mode 1 (high level) or mode 0 (low level), a start pulse is issued in each cycle where `conv_idle` is high, the synchronised pin is at the active level and no pulse was issued in the cycle before. When the pin is at the inactive level or `conv_idle` is low, no pulse is issued.
- R7: When `trig_en` is low in a cycle, the next cycle has no start pulse, whatever the sources do.
- R8: When `src_sel` differs from its value in the previous cycle, any event in that cycle is masked, and the next cycle has no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| trig_en | input | 1 | Trigger mode enable |
| src_sel | input | 3 | Trigger source code |
| pin_mode | input | 2 | External pin qualification mode |
| sw_wr | input | 1 | Write strobe for the software trigger bit |
| sw_wdata | input | 1 | Value written to the software trigger bit |
| conv_idle | input | 1 | Converter is idle and ready for a start |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_evt | input | 4 | Timer event pulses |
| pwm_evt | input | 2 | PWM event pulses |
| start_o | output | 1 | Single-cycle conversion start pulse |

## Verification
The assertions check three rules on every cycle:
- A disabled trigger is followed by a quiet output.
- A change of source code suppresses the next pulse.
- A timer or PWM pulse on the selected line is forwarded after one cycle.

The bench scenarios are needed for behaviour that spans the synchroniser and the mode decoding. This covers edge counting on the pin, the alternating pulse train in level modes, the two-cycle software path and the self-clearing of the software bit. It also covers the silence of every source that is not selected.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
    localparam int SEL_W   = 3;
    localparam int MODE_W  = 2;
    localparam int N_TMR   = 4;
    localparam int N_PWM   = 2;
    localparam int N_SRC   = 1 << SEL_W;

    localparam logic [SEL_W-1:0] SRC_SW    = 3'd0;
    localparam logic [SEL_W-1:0] SRC_PIN   = 3'd1;
    localparam logic [SEL_W-1:0] SRC_TMR0  = 3'd2;
    localparam logic [SEL_W-1:0] SRC_PWM0  = 3'd6;

    typedef enum logic [MODE_W-1:0] {
        PIN_LOW  = 2'd0,
        PIN_HIGH = 2'd1,
        PIN_FALL = 2'd2,
        PIN_RISE = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic             pin_prev;
        logic             sw_bit;
        logic [SEL_W-1:0] sel_prev;
        logic             start;
    } trig_state_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trig_select.sv
module trig_select
    import trig_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_en,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [MODE_W-1:0] pin_mode,
    input  logic              sw_wr,
    input  logic              sw_wdata,
    input  logic              conv_idle,
    input  logic              ext_pin,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [N_PWM-1:0]  pwm_evt,
    output logic              start_o
);
    trig_state_t st_d, st_q;
    logic        pin_sync;
    logic        pin_qual;
    logic [N_SRC-1:0] evt_vec;

    trig_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_pin),
        .sync_o  (pin_sync)
    );

    // Pin qualification per mode
    always_comb begin
        unique case (pin_mode_e'(pin_mode))
            PIN_LOW:  pin_qual = !pin_sync && conv_idle && !st_q.start;
            PIN_HIGH: pin_qual =  pin_sync && conv_idle && !st_q.start;
            PIN_FALL: pin_qual = !pin_sync &&  st_q.pin_prev;
            default:  pin_qual =  pin_sync && !st_q.pin_prev;
        endcase
    end

    // Event vector indexed by source code
    always_comb begin
        evt_vec                  = '0;
        evt_vec[SRC_SW]          = st_q.sw_bit;
        evt_vec[SRC_PIN]         = pin_qual;
        for (int i = 0; i < N_TMR; i++)
            evt_vec[int'(SRC_TMR0) + i] = tmr_evt[i];
        for (int j = 0; j < N_PWM; j++)
            evt_vec[int'(SRC_PWM0) + j] = pwm_evt[j];
    end

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = pin_sync;
        st_d.sw_bit   = sw_wr && sw_wdata;   // one-shot, self-clearing
        st_d.sel_prev = src_sel;
        st_d.start    = trig_en && (src_sel == st_q.sel_prev) && evt_vec[src_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
endmodule

// File: rtl/trig_select_checker.sv
module trig_select_checker
    import trig_sel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trig_en,
    input logic [SEL_W-1:0]  src_sel,
    input logic [N_TMR-1:0]  tmr_evt,
    input logic [N_PWM-1:0]  pwm_evt,
    input logic              start_o
);
    logic [SEL_W-1:0] seen_sel;
    logic             seen_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_sel <= '0;
            seen_vld <= 1'b0;
        end else begin
            seen_sel <= src_sel;
            seen_vld <= 1'b1;
        end
    end

    // R7
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !start_o);

    // R8
    p_sel_change_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && src_sel != seen_sel) |=> !start_o);

    // R2
    p_timer_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && trig_en && src_sel == seen_sel && src_sel == 3'd2 && tmr_evt[0])
        |=> start_o);

    // R2
    p_pwm_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vld && trig_en && src_sel == seen_sel && src_sel == 3'd7 && pwm_evt[1])
        |=> start_o);

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !start_o);
endmodule

bind trig_select trig_select_checker u_trig_select_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_en (trig_en),
    .src_sel (src_sel),
    .tmr_evt (tmr_evt),
    .pwm_evt (pwm_evt),
    .start_o (start_o)
);

// File: tb/trig_select_bench.sv
module trig_select_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       trig_en;
    logic [2:0] src_sel;
    logic [1:0] pin_mode;
    logic       sw_wr, sw_wdata, conv_idle, ext_pin;
    logic [3:0] tmr_evt;
    logic [1:0] pwm_evt;
    logic       start_o;

    int n_chk = 0;
    int n_bad = 0;
    int pulses;

    always #5 clk = ~clk;

    trig_select u_trig_select (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
        .pin_mode(pin_mode), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .conv_idle(conv_idle), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
        .pwm_evt(pwm_evt), .start_o(start_o)
    );

    // vector: [9:7] sel, [6:3] tmr, [2:1] pwm, [0] expected start
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        {3'd2, 4'b0001, 2'b00, 1'b1},
        {3'd2, 4'b0010, 2'b00, 1'b0},
        {3'd3, 4'b0010, 2'b00, 1'b1},
        {3'd5, 4'b1000, 2'b00, 1'b1},
        {3'd4, 4'b1000, 2'b00, 1'b0},
        {3'd6, 4'b0000, 2'b01, 1'b1},
        {3'd7, 4'b0000, 2'b01, 1'b0},
        {3'd7, 4'b0000, 2'b10, 1'b1},
        {3'd1, 4'b1111, 2'b00, 1'b0},
        {3'd0, 4'b0000, 2'b11, 1'b0}
    };

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (start_o !== exp) begin
            n_bad++;
            $display("FAIL %s: start_o=%b expected %b at %0t", req, start_o, exp, $time);
        end
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; trig_en = 0; src_sel = 0; pin_mode = 2'd3;
        sw_wr = 0; sw_wdata = 0; conv_idle = 0; ext_pin = 0;
        tmr_evt = 0; pwm_evt = 0;
        nwait(3);
        check(1'b0, "R1");
        rst_n = 1;
        nwait(1);
        check(1'b0, "R1");

        // R2 vector walk
        trig_en = 1;
        for (int v = 0; v < NV; v++) begin
            src_sel = VEC[v][9:7];
            nwait(3);
            tmr_evt = VEC[v][6:3];
            pwm_evt = VEC[v][2:1];
            nwait(1);
            tmr_evt = 0; pwm_evt = 0;
            check(VEC[v][0], "R2");
            nwait(1);
            check(1'b0, "R2");
        end

        // R3 software trigger
        src_sel = 3'd0; nwait(3);
        sw_wr = 1; sw_wdata = 1;
        nwait(1); sw_wr = 0; sw_wdata = 0;
        check(1'b0, "R3");
        nwait(1); check(1'b1, "R3");
        nwait(1); check(1'b0, "R3");
        sw_wr = 1; sw_wdata = 0;
        nwait(1); sw_wr = 0;
        pulses = 0;
        for (int i = 0; i < 4; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 0) begin n_bad++; $display("FAIL R3: pulses=%0d expected 0", pulses); end

        // R4 self-clear: write while timer source selected, then switch to software
        src_sel = 3'd2; nwait(3);
        sw_wr = 1; sw_wdata = 1;
        nwait(1); sw_wr = 0; sw_wdata = 0;
        nwait(1); src_sel = 3'd0;
        pulses = 0;
        for (int i = 0; i < 5; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 0) begin n_bad++; $display("FAIL R4: pulses=%0d expected 0", pulses); end

        // R5 rising edge
        src_sel = 3'd1; pin_mode = 2'd3; ext_pin = 0; nwait(4);
        ext_pin = 1;
        nwait(2); check(1'b0, "R5");
        nwait(1); check(1'b1, "R5");
        nwait(1); check(1'b0, "R5");
        ext_pin = 0;
        pulses = 0;
        for (int i = 0; i < 5; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 0) begin n_bad++; $display("FAIL R5: rise-mode falling pulses=%0d expected 0", pulses); end
        // falling edge
        pin_mode = 2'd2; ext_pin = 1; nwait(5);
        ext_pin = 0;
        nwait(2); check(1'b0, "R5");
        nwait(1); check(1'b1, "R5");
        nwait(1); check(1'b0, "R5");

        // R6 level modes
        pin_mode = 2'd1; ext_pin = 1; conv_idle = 0;
        pulses = 0;
        for (int i = 0; i < 5; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 0) begin n_bad++; $display("FAIL R6: busy pulses=%0d expected 0", pulses); end
        conv_idle = 1;
        pulses = 0;
        for (int i = 0; i < 6; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 3) begin n_bad++; $display("FAIL R6: high-level pulses=%0d expected 3", pulses); end
        pin_mode = 2'd0; nwait(1);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 0) begin n_bad++; $display("FAIL R6: low-mode high-pin pulses=%0d expected 0", pulses); end
        ext_pin = 0; nwait(3);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin nwait(1); pulses += int'(start_o); end
        n_chk++;
        if (pulses != 3) begin n_bad++; $display("FAIL R6: low-level pulses=%0d expected 3", pulses); end
        conv_idle = 0; nwait(2);

        // R7 disabled
        src_sel = 3'd4; nwait(3);
        trig_en = 0; tmr_evt = 4'b0100;
        nwait(1); tmr_evt = 0; trig_en = 1;
        check(1'b0, "R7");

        // R8 select change masks same-cycle event
        src_sel = 3'd3; nwait(3);
        src_sel = 3'd2; tmr_evt = 4'b0001;
        nwait(1); tmr_evt = 0;
        check(1'b0, "R8");
        tmr_evt = 4'b0001;
        nwait(1); tmr_evt = 0;
        check(1'b1, "R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule